// File: doc/BRIEF.md
# Phase Current Averaging and Overcurrent Detect

This block sits beside the PWM core of a multi-phase buck controller. Each phase has a low-side conduction interval once per switching period. The PWM block marks the start of that interval with a one-clock pulse. A fixed third of a period later, this block raises a strobe for that phase. The strobe asks the converter front end for a current reading and latches the digitised value.

Once the last active phase has been latched, the block averages the readings of the active phases only. The phase count is 2, 3 or 4. The block then publishes three results:
- the average, as a droop term for the reference path;
- a signed, saturated correction per phase for the PWM comparators;
- a one-clock overcurrent pulse when the average reaches 165% of the nominal full-load code.

The pulse is blocked while the start-up sequencer reports that the outputs are released.

Top module: `phase_current_balancer`

## Requirements
- R1: `sample_stb[i]` is high for exactly one clock, PERIOD/3 (integer division) clocks after the clock in which `lowside_start[i]` is high.
- R2: The reading for phase i is the value on `isense[i*SW +: SW]` during the clock in which `sample_stb[i]` is high.
- R3: `phase_sel` sets the active phases. Code 0 selects phases 0–1, code 1 selects phases 0–2, and codes 2 and 3 select phases 0–3. `droop` is the sum of the active readings divided by the active count, rounded down.
- R4: `droop`, `corr` and `oc_trip` update only on the second rising edge after the strobe of the highest-numbered active phase. Otherwise `droop` and `corr` hold their values.
- R5: For an active phase, `corr[i*CW +: CW]` is the signed value average minus reading, saturated to the range -2^(CW-1) to 2^(CW-1)-1. A positive value means the phase carries less than the average.
- R6: Readings of inactive phases do not affect `droop`, and `corr` for an inactive phase is 0.
- R7: `oc_trip` is high for one clock when the newly computed average is at least ceil(1.65 × FULL_CODE).
- R8: `oc_trip` stays low after any update made while `outputs_off` is high.
- R9: After reset, `droop`, `corr`, `oc_trip` and `sample_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_sel | input | 2 | Active phase count code |
| outputs_off | input | 1 | High while the power stage outputs are released |
| lowside_start | input | NPH | One-clock pulse per phase at low-side turn-on |
| isense | input | NPH*SW | Unsigned current code per phase, phase 0 in the low bits |
| sample_stb | output | NPH | Sample strobe per phase |
| droop | output | SW | Average current of the active phases |
| corr | output | NPH*CW | Signed per-phase balance correction, phase 0 in the low bits |
| oc_trip | output | 1 | One-clock overcurrent pulse |

## Verification
The bench builds the block with PERIOD=24, SW=10, CW=8 and FULL_CODE=200, which gives a strobe delay of 8 clocks and a trip code of 330. The correction is much narrower than the reading, so a spread of 0 against 400 drives both saturation limits. Readings near the top code in three-phase mode check the multiply-and-shift divide where rounding errors would show. Trip codes of 329 and 330 bracket the threshold exactly.

// File: rtl/phase_current_balancer.sv
module phase_current_balancer #(
  parameter int NPH       = 4,
  parameter int SW        = 10,
  parameter int CW        = 8,
  parameter int PERIOD    = 30,
  parameter int FULL_CODE = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        phase_sel,
  input  logic              outputs_off,
  input  logic [NPH-1:0]    lowside_start,
  input  logic [NPH*SW-1:0] isense,
  output logic [NPH-1:0]    sample_stb,
  output logic [SW-1:0]     droop,
  output logic [NPH*CW-1:0] corr,
  output logic              oc_trip
);
  localparam int DLY  = PERIOD / 3;
  localparam int DW   = $clog2(DLY + 1);
  localparam int IW   = $clog2(NPH);
  localparam int SUMW = SW + IW;
  localparam int SH   = SUMW + 1;
  localparam int MUL  = ((1 << SH) + 2) / 3;
  localparam int PW   = SUMW + SH;
  localparam int TRIP = (FULL_CODE * 33 + 19) / 20;
  localparam logic signed [SW:0] CMAX = (SW+1)'(2 ** (CW - 1) - 1);
  localparam logic signed [SW:0] CMIN = (SW+1)'(-(2 ** (CW - 1)));

  logic [2:0]      nreq, nact;
  logic [NPH-1:0]  act;
  logic [SW-1:0]   samp [NPH];
  logic [SUMW-1:0] sum;
  logic [PW-1:0]   prod;
  logic [SW-1:0]   avg_n;
  logic            calc;

  assign nreq = (phase_sel == 2'd0) ? 3'd2 : (phase_sel == 2'd1) ? 3'd3 : 3'd4;
  assign nact = (nreq > 3'(NPH)) ? 3'(NPH) : nreq;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic [DW-1:0]        cnt;
    logic signed [SW:0]   diff;
    logic signed [CW-1:0] sat, corr_r;

    assign act[i]        = 3'(i) < nact;
    assign sample_stb[i] = (cnt == DW'(1));
    assign diff = $signed({1'b0, avg_n}) - $signed({1'b0, samp[i]});
    assign sat  = (diff > CMAX) ? CMAX[CW-1:0] :
                  (diff < CMIN) ? CMIN[CW-1:0] : diff[CW-1:0];
    assign corr[i*CW +: CW] = corr_r;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt     <= '0;
        samp[i] <= '0;
        corr_r  <= '0;
      end else begin
        if (lowside_start[i]) cnt <= DW'(DLY);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
        if (sample_stb[i])    samp[i] <= isense[i*SW +: SW];
        if (calc)             corr_r <= act[i] ? sat : '0;
      end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NPH; i++)
      if (act[i]) sum = sum + SUMW'(samp[i]);
  end

  assign prod = PW'(sum) * PW'(MUL);

  always_comb
    case (nact)
      3'd2:    avg_n = SW'(sum >> 1);
      3'd3:    avg_n = SW'(prod >> SH);
      default: avg_n = SW'(sum >> 2);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      calc    <= 1'b0;
      droop   <= '0;
      oc_trip <= 1'b0;
    end else begin
      calc    <= sample_stb[IW'(nact - 3'd1)];
      oc_trip <= calc && (int'(avg_n) >= TRIP) && !outputs_off;
      if (calc) droop <= avg_n;
    end
endmodule

// File: rtl/phase_current_balancer_chk.sv
module phase_current_balancer_chk #(
  parameter int NPH       = 4,
  parameter int SW        = 10,
  parameter int FULL_CODE = 200
) (
  input logic           clk,
  input logic           rst_n,
  input logic           outputs_off,
  input logic [NPH-1:0] sample_stb,
  input logic [SW-1:0]  droop,
  input logic           oc_trip
);
  localparam int TRIP_CODE = (FULL_CODE * 165 + 99) / 100;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb[0] |=> !sample_stb[0]);                                        // R1
  AST_DROOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|sample_stb, 2) |-> $stable(droop));                               // R4
  AST_OC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> !oc_trip);                                                    // R7
  AST_OC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> int'(droop) >= TRIP_CODE);                                    // R7
  AST_OC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_off |=> !oc_trip);                                                // R8
endmodule

bind phase_current_balancer phase_current_balancer_chk #(
  .NPH(NPH), .SW(SW), .FULL_CODE(FULL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .outputs_off(outputs_off),
  .sample_stb(sample_stb), .droop(droop), .oc_trip(oc_trip)
);

// File: tb/tb_phase_current_balancer.sv
`timescale 1ns/1ps
module tb_phase_current_balancer;
  localparam int NPH = 4, SW = 10, CW = 8, PERIOD = 24, FULL = 200;
  localparam int DLY = PERIOD / 3;

  logic clk = 0, rst_n = 0, outputs_off = 0;
  logic [1:0] phase_sel = 2'd2;
  logic [NPH-1:0] lowside_start = '0;
  logic [NPH*SW-1:0] isense = '0;
  logic [NPH-1:0] sample_stb;
  logic [SW-1:0] droop;
  logic [NPH*CW-1:0] corr;
  logic oc_trip;

  int checks = 0, failures = 0, trip, last_d = 0;
  bit done = 0;
  int q_d[$], q_o[$];
  logic [NPH*CW-1:0] q_c[$];

  always #2.5 clk = ~clk;

  phase_current_balancer #(.NPH(NPH), .SW(SW), .CW(CW), .PERIOD(PERIOD), .FULL_CODE(FULL)) dut (
    .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel), .outputs_off(outputs_off),
    .lowside_start(lowside_start), .isense(isense), .sample_stb(sample_stb),
    .droop(droop), .corr(corr), .oc_trip(oc_trip));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nact_of(input int psel);
    return psel == 0 ? 2 : psel == 1 ? 3 : 4;
  endfunction

  function automatic int satc(input int v);
    return v > 127 ? 127 : v < -128 ? -128 : v;
  endfunction

  task automatic run_period(input int psel, input int s0, input int s1, input int s2,
                            input int s3, input bit off);
    int s[4];
    int n, sum, avg;
    logic [NPH*CW-1:0] ec;
    s = '{s0, s1, s2, s3};
    n = nact_of(psel);
    sum = 0;
    for (int i = 0; i < n; i++) sum += s[i];
    avg = sum / n;
    ec = '0;
    for (int i = 0; i < n; i++) ec[i*CW +: CW] = CW'(satc(avg - s[i]));
    q_d.push_back(avg);
    q_c.push_back(ec);
    q_o.push_back((avg >= trip && !off) ? 1 : 0);
    @(negedge clk);
    phase_sel = 2'(psel);
    outputs_off = off;
    isense = {SW'(s3), SW'(s2), SW'(s1), SW'(s0)};
    for (int i = 0; i < n; i++) begin
      lowside_start = NPH'(1 << i);
      @(negedge clk);
      lowside_start = '0;
      @(negedge clk);
    end
    repeat (DLY + 8) @(negedge clk);
    chk(droop == SW'(avg), "R4 droop held after update", int'(droop), avg);
    last_d = avg;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && sample_stb[nact_of(int'(phase_sel)) - 1]) begin
        int ed, eo;
        logic [NPH*CW-1:0] ecv;
        @(negedge clk);
        @(negedge clk);
        ed = q_d.pop_front();
        eo = q_o.pop_front();
        ecv = q_c.pop_front();
        chk(droop == SW'(ed), "R2/R3 droop average", int'(droop), ed);
        for (int i = 0; i < NPH; i++)
          chk(corr[i*CW +: CW] == ecv[i*CW +: CW], $sformatf("R5/R6 corr phase %0d", i),
              int'($signed(corr[i*CW +: CW])), int'($signed(ecv[i*CW +: CW])));
        chk(oc_trip == eo[0], "R7/R8 oc pulse", int'(oc_trip), eo);
        @(negedge clk);
        chk(oc_trip == 1'b0, "R7 oc one clock", int'(oc_trip), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    trip = (FULL * 165 + 99) / 100;
    repeat (3) @(negedge clk);
    chk(droop == '0, "R9 droop reset", int'(droop), 0);
    chk(corr == '0, "R9 corr reset", int'(corr), 0);
    chk(oc_trip == 1'b0 && sample_stb == '0, "R9 flags reset", int'({oc_trip, sample_stb}), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 strobe delay, phase 2 alone in 4-phase mode
    lowside_start = 4'b0100;
    @(negedge clk);
    lowside_start = '0;
    for (int k = 1; k <= DLY + 1; k++) begin
      if (k >= DLY - 1)
        chk(sample_stb[2] == (k == DLY), $sformatf("R1 strobe at +%0d", k),
            int'(sample_stb[2]), int'(k == DLY));
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    run_period(2, 200, 200, 200, 200, 0);
    run_period(3, 100, 200, 300, 250, 0);
    run_period(1, 100, 101, 103, 900, 0);     // R6 phase 3 excluded
    run_period(1, 1023, 1023, 1022, 0, 0);    // divide-by-3 near top code
    run_period(0, 0, 400, 1000, 1000, 0);     // R5 saturation both ways
    run_period(0, 329, 330, 0, 0, 0);         // just below trip
    run_period(0, 330, 330, 0, 0, 0);         // exactly at trip
    run_period(2, 400, 400, 400, 400, 1);     // R8 blocked
    run_period(2, 400, 400, 400, 400, 0);
    repeat (5) @(negedge clk);
    chk(droop == SW'(last_d), "R4 droop stable between periods", int'(droop), last_d);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule